// File: doc/BRIEF.md
# Flash Lock-Bit Programming Sequencer

This block sits on the host side of a parallel flash command bus. It protects either one erase block or the whole device by setting a lock-bit, then reads back the device status and turns it into a result code. A single `start` pulse begins an operation. `master_sel` selects the device-wide lock in place of a block lock. `blk_addr` names the block to lock.

The sequencer writes a setup command and then a confirm command. It reads the status byte repeatedly until the device's internal state machine reports ready. It then decodes the error flags in a fixed priority order. After an error it clears the status flags. It always leaves the device in read-array mode before it reports. A busy wait that runs too long ends with its own timeout code.

Several lock operations can be queued with `defer_check` set. Because the device keeps its error flags until they are cleared, one full check on the last operation covers the whole batch.

Top module: `lockbit_seq`

## Requirements
- R1: While reset is held and after it is released, `bus_we`, `bus_re` and `done` are low until a start is accepted.
- R2: In the cycle after `start` is sampled in idle, the block writes 0x60. The write goes to `blk_addr` for a block lock, or to parameter `MASTER_ADDR` for a master lock.
- R3: In the next cycle it writes the confirm code to the same address: 0x01 for a block lock, 0xF1 for the master lock.
- R4: After the confirm write, it asserts `bus_re` at the same address once per cycle. It samples `rd_data` in that cycle and keeps reading while bit 7 is 0 (busy).
- R5: When bit 7 reads 1, the result is decided by the first matching rule below:
  - bit 3 = 1 gives code 1 (supply error);
  - bits 5 and 4 both 1 give code 2 (command sequence error);
  - bit 4 = 1 gives code 3 (lock-set error);
  - bit 1 = 1 gives code 4 (device protected);
  - otherwise the code is 0 (success). Bit 5 alone is not an error.
- R6: After an error code from R5, the block writes 0x50 (clear status) and then 0xFF (read array). After success it writes only 0xFF. All these writes go to the operation address.
- R7: `done` is high for exactly one cycle, with `result` valid in that cycle. Counting from the edge that samples `start`, with B busy reads, `done` is seen in cycle 5+B on success and in cycle 6+B on an error.
- R8: If `POLL_LIMIT` consecutive reads all show busy, the block reports code 5 in the following cycle (cycle 3+`POLL_LIMIT`) and makes no further writes.
- R9: With `defer_check` high at start, the first ready read ends the operation with code 6 in cycle 4+B. There is no decode, clear or read-array write, so the error flags carry over to a later checked operation.
- R10: A `start` that arrives while an operation runs is ignored: it adds no bus write and changes no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled in idle only) |
| master_sel | input | 1 | 1 = set master lock, 0 = set block lock |
| defer_check | input | 1 | 1 = skip the full status check for a queued operation |
| blk_addr | input | AW | Block address for a block lock |
| rd_data | input | 8 | Status byte returned by the flash during a read cycle |
| bus_we | output | 1 | Command write strobe |
| bus_re | output | 1 | Status read strobe |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 8 | Command byte (0 when not writing) |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code, valid with `done` |

## Verification
Every result has a fixed due cycle, counted from the edge that samples `start`:
- setup in cycle 1 and confirm in cycle 2;
- the first status read in cycle 3;
- `done` in cycle 4+B, 5+B or 6+B, depending on whether the check is deferred, passes or fails;
- a timeout in cycle 3+`POLL_LIMIT`.

The bench counts falling edges from that sampling edge and compares the count at which `done` appears with the figure it computes from the injected busy length and error bits. A bus model logs every write with its address at the rising edge, so the command order can be compared in full. A sweep covers every combination of the four decoded error bits, for both lock kinds, with varied busy lengths.

// File: rtl/lockbit_pkg.sv
// Shared types and command bytes for the lock-bit sequencer.
// Assumes an 8-bit flash data bus.
package lockbit_pkg;
    typedef enum logic [2:0] {
        RES_OK     = 3'd0,
        RES_VPP    = 3'd1,
        RES_SEQ    = 3'd2,
        RES_LOCK   = 3'd3,
        RES_PROT   = 3'd4,
        RES_TMO    = 3'd5,
        RES_QUEUED = 3'd6
    } res_e;

    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_CONF, S_POLL, S_CLR, S_RDARR, S_DONE
    } st_e;

    localparam logic [7:0] OP_SETUP = 8'h60;
    localparam logic [7:0] OP_BLK   = 8'h01;
    localparam logic [7:0] OP_MST   = 8'hF1;
    localparam logic [7:0] OP_CLR   = 8'h50;
    localparam logic [7:0] OP_RDARR = 8'hFF;

    localparam int ST_READY = 7;
    localparam int ST_VPP   = 3;
    localparam int ST_LOCK  = 4;
    localparam int ST_ERASE = 5;
    localparam int ST_PROT  = 1;
endpackage

// File: rtl/lockbit_status_decode.sv
// Turns a ready status byte into a result code using a fixed priority.
// Assumes the caller only uses the output once the ready bit is set.
module lockbit_status_decode
    import lockbit_pkg::*;
(
    input  logic [7:0] status,
    output res_e       code
);
    // Priority decode of the error flags, highest first.
    always_comb begin
        if (status[ST_VPP])
            code = RES_VPP;
        else if (status[ST_LOCK] && status[ST_ERASE])
            code = RES_SEQ;
        else if (status[ST_LOCK])
            code = RES_LOCK;
        else if (status[ST_PROT])
            code = RES_PROT;
        else
            code = RES_OK;
    end
endmodule

// File: rtl/lockbit_poll_timer.sv
// Counts consecutive busy status reads and flags expiry on the
// POLL_LIMIT-th one. Assumes POLL_LIMIT >= 1.
module lockbit_poll_timer #(
    parameter int POLL_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic poll,
    input  logic busy,
    output logic expired
);
    localparam int CW = $clog2(POLL_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(POLL_LIMIT - 1);

    logic [CW-1:0] cnt;

    assign expired = poll && busy && (cnt == LAST);

    // Count busy reads; restart whenever polling stops or ready is seen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (poll && busy && !expired)
            cnt <= cnt + 1'b1;
        else
            cnt <= '0;
    end

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/lockbit_seq.sv
// Lock-bit programming sequencer: setup/confirm command pair, busy poll,
// prioritised status decode, status clear on error, read-array restore.
// Assumes a flash that returns its status byte on rd_data in the same
// cycle as bus_re.
module lockbit_seq
    import lockbit_pkg::*;
#(
    parameter int AW = 21,
    parameter int POLL_LIMIT = 64,
    parameter logic [AW-1:0] MASTER_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          master_sel,
    input  logic          defer_check,
    input  logic [AW-1:0] blk_addr,
    input  logic [7:0]    rd_data,
    output logic          bus_we,
    output logic          bus_re,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    output logic          done,
    output logic [2:0]    result
);
    st_e           state;
    logic [AW-1:0] addr_q;
    logic          master_q;
    logic          defer_q;
    res_e          res_q;
    res_e          dec_code;
    logic          tmo;
    logic          ready;

    assign ready = rd_data[ST_READY];

    lockbit_status_decode u_dec (
        .status (rd_data),
        .code   (dec_code)
    );

    lockbit_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .poll    (state == S_POLL),
        .busy    (!ready),
        .expired (tmo)
    );

    // Bus strobes and command byte from the current state.
    always_comb begin
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_wdata = 8'h00;
        unique case (state)
            S_SETUP: begin bus_we = 1'b1; bus_wdata = OP_SETUP; end
            S_CONF:  begin bus_we = 1'b1; bus_wdata = master_q ? OP_MST : OP_BLK; end
            S_POLL:  bus_re = 1'b1;
            S_CLR:   begin bus_we = 1'b1; bus_wdata = OP_CLR; end
            S_RDARR: begin bus_we = 1'b1; bus_wdata = OP_RDARR; end
            default: ;
        endcase
    end

    assign bus_addr = addr_q;
    assign done     = (state == S_DONE);
    assign result   = res_q;

    // Operation sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            addr_q   <= '0;
            master_q <= 1'b0;
            defer_q  <= 1'b0;
            res_q    <= RES_OK;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    addr_q   <= master_sel ? MASTER_ADDR : blk_addr;
                    master_q <= master_sel;
                    defer_q  <= defer_check;
                    state    <= S_SETUP;
                end
                S_SETUP: state <= S_CONF;
                S_CONF:  state <= S_POLL;
                S_POLL: begin
                    if (ready) begin
                        if (defer_q) begin
                            res_q <= RES_QUEUED;
                            state <= S_DONE;
                        end else begin
                            res_q <= dec_code;
                            state <= (dec_code == RES_OK) ? S_RDARR : S_CLR;
                        end
                    end else if (tmo) begin
                        res_q <= RES_TMO;
                        state <= S_DONE;
                    end
                end
                S_CLR:   state <= S_RDARR;
                S_RDARR: state <= S_DONE;
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R4
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    // R3
    confirm_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_wdata == OP_BLK || bus_wdata == OP_MST)) |->
        ($past(bus_we) && $past(bus_wdata) == OP_SETUP && $stable(bus_addr)));

    // R6
    clear_then_rdarr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_wdata == OP_CLR) |=> (bus_we && bus_wdata == OP_RDARR));

    // R6
    ok_after_rdarr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_OK) |-> ($past(bus_we) && $past(bus_wdata) == OP_RDARR));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    tmo_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_TMO) |-> $past(bus_re));
endmodule

// File: tb/lockbit_seq_test.sv
`timescale 1ns/1ps
module lockbit_seq_test;
    localparam int AW = 21;
    localparam int PL = 16;
    localparam logic [AW-1:0] MADDR = 21'h1F0000;

    logic clk = 0, rst_n = 0;
    logic start = 0, master_sel = 0, defer_check = 0;
    logic [AW-1:0] blk_addr = '0;
    logic [7:0] rd_data;
    logic bus_we, bus_re, done;
    logic [AW-1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [2:0] result;

    int total = 0, bad = 0;

    always #4 clk = ~clk;

    lockbit_seq #(.AW(AW), .POLL_LIMIT(PL), .MASTER_ADDR(MADDR)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .master_sel(master_sel),
        .defer_check(defer_check), .blk_addr(blk_addr), .rd_data(rd_data),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .done(done), .result(result));

    // Flash model: status flags, busy countdown, write log.
    logic [6:0] sreg;
    int busy_n, conf_busy;
    logic [7:0] inj;
    logic [7:0] log_d [0:15];
    logic [AW-1:0] log_a [0:15];
    int log_n;
    logic log_clr;

    assign rd_data = (busy_n > 0) ? {1'b0, sreg} : {1'b1, sreg};

    always @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0; busy_n <= 0;
        end else begin
            if (bus_we) begin
                if (bus_wdata == 8'h01 || bus_wdata == 8'hF1) begin
                    busy_n <= conf_busy;
                    sreg   <= sreg | inj[6:0];
                end else if (bus_wdata == 8'h50)
                    sreg <= sreg & ~7'b0111010;
            end
            if (bus_re && busy_n > 0) busy_n <= busy_n - 1;
        end
        if (log_clr) log_n <= 0;
        else if (bus_we && log_n < 16) begin
            log_d[log_n] <= bus_wdata;
            log_a[log_n] <= bus_addr;
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_res(input logic [7:0] b);
        if (b[3]) return 1;
        if (b[5] && b[4]) return 2;
        if (b[4]) return 3;
        if (b[1]) return 4;
        return 0;
    endfunction

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    // Start one operation; return the falling-edge count at which done appears.
    task automatic run_op(input bit m, input bit d, input logic [AW-1:0] a,
                          input logic [7:0] iv, input int bv, input bit restart,
                          output int lat, output int res);
        log_clr = 1; @(negedge clk); log_clr = 0;
        inj = iv; conf_busy = bv;
        master_sel = m; defer_check = d; blk_addr = a; start = 1;
        lat = 0; res = -1;
        @(negedge clk);
        start = 0;
        lat = 1;
        while (!done && lat < 200) begin
            if (restart && lat == 2) begin
                start = 1; master_sel = !m; blk_addr = ~a;
            end else start = 0;
            @(negedge clk);
            lat++;
        end
        start = 0;
        if (done) res = int'(result);
        @(negedge clk);
        chk(!done, "R7 done one cycle", done, 0);
    endtask

    task automatic check_writes(input bit m, input bit d, input logic [AW-1:0] a,
                                input int code, input string tag);
        logic [7:0] ex [0:3];
        int n;
        logic [AW-1:0] ea;
        ea = m ? MADDR : a;
        ex[0] = 8'h60; ex[1] = m ? 8'hF1 : 8'h01; n = 2;
        if (!d) begin
            if (code != 0) begin ex[n] = 8'h50; n++; end
            ex[n] = 8'hFF; n++;
        end
        chk(log_n == n, {tag, " write count"}, log_n, n);
        for (int i = 0; i < n && i < log_n; i++) begin
            chk(log_d[i] == ex[i], {tag, " write data"}, log_d[i], ex[i]);
            chk(log_a[i] == ea, {tag, " write addr"}, log_a[i], ea);
        end
    endtask

    initial begin
        #1_200_000;
        bad++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat, res, er, el;
        logic [7:0] iv;
        logic [AW-1:0] a;
        log_clr = 1; inj = 0; conf_busy = 0;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(!bus_we && !bus_re && !done, "R1 outputs in reset", {bus_we, bus_re, done}, 0);
        rst_n = 1; log_clr = 0;
        @(negedge clk);
        chk(!bus_we && !bus_re && !done, "R1 idle after reset", {bus_we, bus_re, done}, 0);

        // Sweep of error bits 1,3,4,5 for both lock kinds (R2..R7)
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 16; p++) begin
                do_reset();
                iv = {2'b00, p[3], p[2], p[1], 1'b0, p[0], 1'b0};
                a = AW'(21'h00A000 + p * 21'h010000);
                run_op(m[0], 1'b0, a, iv, p % 3, 1'b0, lat, res);
                er = exp_res(iv);
                el = 5 + (p % 3) + ((er != 0) ? 1 : 0);
                chk(res == er, "R5 result code", res, er);
                chk(lat == el, "R7 done latency", lat, el);
                check_writes(m[0], 1'b0, a, er, "R2 R3 R6");
            end
        end

        // R4 long busy wait below the limit
        do_reset();
        run_op(1'b0, 1'b0, 21'h000123, 8'h00, PL - 1, 1'b0, lat, res);
        chk(res == 0, "R4 long poll result", res, 0);
        chk(lat == 5 + PL - 1, "R4 long poll latency", lat, 5 + PL - 1);

        // R8 timeout
        do_reset();
        run_op(1'b0, 1'b0, 21'h000456, 8'h00, 1000, 1'b0, lat, res);
        chk(res == 5, "R8 timeout code", res, 5);
        chk(lat == 3 + PL, "R8 timeout latency", lat, 3 + PL);
        chk(log_n == 2, "R8 no writes after timeout", log_n, 2);

        // R9 deferred check then full check picks up carried flags
        do_reset();
        run_op(1'b0, 1'b1, 21'h020000, 8'h10, 2, 1'b0, lat, res);
        chk(res == 6, "R9 queued code", res, 6);
        chk(lat == 4 + 2, "R9 queued latency", lat, 6);
        check_writes(1'b0, 1'b1, 21'h020000, 0, "R9");
        run_op(1'b1, 1'b0, 21'h030000, 8'h00, 1, 1'b0, lat, res);
        chk(res == 3, "R9 carried lock error", res, 3);
        check_writes(1'b1, 1'b0, 21'h030000, 3, "R9 final");

        // R10 start ignored while busy
        do_reset();
        run_op(1'b0, 1'b0, 21'h044000, 8'h00, 3, 1'b1, lat, res);
        chk(res == 0, "R10 result unchanged", res, 0);
        chk(lat == 8, "R10 latency unchanged", lat, 8);
        check_writes(1'b0, 1'b0, 21'h044000, 0, "R10");
        repeat (4) @(negedge clk);
        chk(log_n == 3 && !bus_we, "R10 no extra operation", log_n, 3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule